// File: doc/BRIEF.md
# Audio codec volume and control register file

This block is the register file of an audio codec that a host controls over an index. The host drives a 7-bit index with a write strobe and 16-bit data, or with a read strobe. Read data comes back registered on the next clock. The file holds nine volume registers (six stereo, three single-channel), a fixed identity register, a retained configuration register and a control register that carries the mute-split enable.

The block keeps every volume field at five bits. If the host writes the sixth (overflow) bit of a field, the field saturates to its maximum. From the stored bits the block continuously produces an effective attenuation code and an effective mute flag for each mixer lane. A downstream mixer uses them directly. The right-channel mute bit only matters while mute-split is enabled. Any write to index 00h returns the file to its defaults, except the configuration register.

Top module: `codec_ctrl_regs`

## Requirements
- R1: Index bit 0 is ignored. An odd index reads and writes the same register as the even index just below it.
- R2: A write to index 00h (any data) restores every register to its default on the next clock, except the configuration register at 74h, which keeps its value.
- R3: A read of index 00h returns {6'b0, ID_CODE}. Bits [14:10] are therefore zero, and so is bit 15. Writes never change this value.
- R4: The stereo registers are master 02h, headphone 04h, line 10h, CD 12h, AUX 16h and PCM 18h. Each has a left/common mute in bit 15, left attenuation in [12:8], right mute in bit 7 and right attenuation in [4:0]. Register k of the order 02h,04h,06h,0Ch,0Eh,10h,12h,16h,18h drives lane 2k (left) and lane 2k+1 (right). Lane j uses atten_o[5j+4:5j] and mute_o[j].
- R5: A write with bit 13 set stores 11111 as the left attenuation. A write with bit 5 set stores 11111 as the right (or only) attenuation. Bits 13 and 5 themselves read back as 0.
- R6: The single-channel registers are mono 06h, phone 0Ch and mic 0Eh. Each holds a mute in bit 15 and attenuation in [4:0], with bit 5 saturating. Both of its lanes carry the same attenuation and mute.
- R7: The right lane of a stereo register is muted by bit 7 only while mute-split (bit 12 of 76h) is 1. While it is 0, bit 15 mutes both lanes and bit 7 has no effect.
- R8: Reserved bits read as 0. A read of an index outside 00h, 02h–06h, 0Ch–12h, 16h, 18h, 74h and 76h returns 0000h. A write to such an index changes no register and no output.
- R9: After rst_ni every volume register reads 8000h (muted, zero attenuation), 74h and 76h read 0000h, and all lanes are muted with attenuation 0.
- R10: A read returns the value held before any same-cycle write. rdata_o changes one clock after re_i and holds between reads.
- R11: Index 74h stores bits [7:0] of the written value and reads the rest as 0. Only rst_ni clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| idx_i | input | 7 | Register index |
| wdata_i | input | 16 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 16 | Registered read data |
| atten_o | output | 90 | Effective 5-bit attenuation per lane, 18 lanes |
| mute_o | output | 18 | Effective mute per lane |

## Verification
The bench goes after the overflow bits 13 and 5. A design that stored them raw would read back 6-bit fields or leave the lane attenuation short of 11111. It writes through odd indices, which a design decoding all seven bits would drop. It toggles mute-split around a register whose bit 7 differs from bit 15, so leaking bit 7 into the lane, or ignoring it once split is on, shows on mute_o. It issues a soft reset after loading 74h and checks that 74h survives while 76h and the volumes revert. It also reads and writes in the same cycle to catch a read path that returns the new value.

// File: rtl/codec_regs_pkg.sv
package codec_regs_pkg;
  localparam int DW        = 16;
  localparam int IW        = 7;
  localparam int ATT_W     = 5;
  localparam int HI_LSB    = 8;
  localparam int NUM_VOL   = 9;
  localparam int LANES     = 2 * NUM_VOL;
  localparam int CFG_W     = 8;
  localparam int SPLIT_BIT = 12;

  localparam logic [IW-1:0] IDX_ID   = 7'h00;
  localparam logic [IW-1:0] IDX_CFG  = 7'h74;
  localparam logic [IW-1:0] IDX_MISC = 7'h76;

  // order fixes the lane numbering at the ports
  localparam logic [IW-1:0] VOL_IDX [NUM_VOL] =
    '{7'h02, 7'h04, 7'h06, 7'h0C, 7'h0E, 7'h10, 7'h12, 7'h16, 7'h18};
  localparam logic [NUM_VOL-1:0] VOL_STEREO = 9'b1_1110_0011;

  function automatic logic idx_known(input logic [IW-1:0] idx);
    logic hit;
    hit = (idx[IW-1:1] == IDX_ID[IW-1:1]) || (idx[IW-1:1] == IDX_CFG[IW-1:1]) ||
          (idx[IW-1:1] == IDX_MISC[IW-1:1]);
    for (int k = 0; k < NUM_VOL; k++) hit |= (idx[IW-1:1] == VOL_IDX[k][IW-1:1]);
    return hit;
  endfunction
endpackage

// File: rtl/codec_idx_decode.sv
module codec_idx_decode
  import codec_regs_pkg::*;
(
  input  logic [IW-1:0]      idx_i,
  output logic [NUM_VOL-1:0] vol_sel_o,
  output logic               id_sel_o,
  output logic               cfg_sel_o,
  output logic               misc_sel_o
);
  logic [IW-2:0] word;
  logic          unused_lsb;

  assign word       = idx_i[IW-1:1];
  assign unused_lsb = idx_i[0];

  assign id_sel_o   = (word == IDX_ID[IW-1:1]);
  assign cfg_sel_o  = (word == IDX_CFG[IW-1:1]);
  assign misc_sel_o = (word == IDX_MISC[IW-1:1]);

  for (genvar k = 0; k < NUM_VOL; k++) begin : g_sel
    assign vol_sel_o[k] = (word == VOL_IDX[k][IW-1:1]);
  end
endmodule

// File: rtl/codec_vol_reg.sv
module codec_vol_reg
  import codec_regs_pkg::*;
#(
  parameter bit STEREO = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             wr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             split_i,
  output logic [DW-1:0]    rd_o,
  output logic [ATT_W-1:0] att_l_o,
  output logic [ATT_W-1:0] att_r_o,
  output logic             mute_l_o,
  output logic             mute_r_o
);
  localparam int GAP = HI_LSB - 1 - ATT_W;

  function automatic logic [ATT_W-1:0] sat(input logic [ATT_W:0] f);
    return f[ATT_W] ? {ATT_W{1'b1}} : f[ATT_W-1:0];
  endfunction

  logic             m_q;
  logic [ATT_W-1:0] ar_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q  <= 1'b1;
      ar_q <= '0;
    end else if (soft_rst_i) begin
      m_q  <= 1'b1;
      ar_q <= '0;
    end else if (wr_i) begin
      m_q  <= wdata_i[DW-1];
      ar_q <= sat(wdata_i[ATT_W:0]);
    end
  end

  assign att_r_o  = ar_q;
  assign mute_l_o = m_q;

  if (STEREO) begin : g_stereo
    logic             rm_q;
    logic [ATT_W-1:0] al_q;
    logic             unused_w;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rm_q <= 1'b0;
        al_q <= '0;
      end else if (soft_rst_i) begin
        rm_q <= 1'b0;
        al_q <= '0;
      end else if (wr_i) begin
        rm_q <= wdata_i[HI_LSB-1];
        al_q <= sat(wdata_i[HI_LSB+ATT_W:HI_LSB]);
      end
    end

    assign unused_w = ^{wdata_i[DW-2:HI_LSB+ATT_W+1], wdata_i[HI_LSB-2:ATT_W+1]};
    assign att_l_o  = al_q;
    assign mute_r_o = split_i ? rm_q : m_q;
    assign rd_o     = {m_q, {GAP{1'b0}}, al_q, rm_q, {GAP{1'b0}}, ar_q};
  end else begin : g_mono
    logic unused_w;
    assign unused_w = ^{wdata_i[DW-2:ATT_W+1], split_i};
    assign att_l_o  = ar_q;
    assign mute_r_o = m_q;
    assign rd_o     = {m_q, {(DW-1-ATT_W){1'b0}}, ar_q};
  end
endmodule

// File: rtl/codec_ctrl_regs.sv
module codec_ctrl_regs
  import codec_regs_pkg::*;
#(
  parameter logic [9:0] ID_CODE = 10'h190
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [IW-1:0]          idx_i,
  input  logic [DW-1:0]          wdata_i,
  input  logic                   we_i,
  input  logic                   re_i,
  output logic [DW-1:0]          rdata_o,
  output logic [LANES*ATT_W-1:0] atten_o,
  output logic [LANES-1:0]       mute_o
);
  logic [NUM_VOL-1:0] vol_sel;
  logic               id_sel, cfg_sel, misc_sel;
  logic               soft_rst;
  logic               split_q;
  logic [CFG_W-1:0]   cfg_q;
  logic [DW-1:0]      vol_rd [NUM_VOL];
  logic [DW-1:0]      rd_next, rdata_q;

  codec_idx_decode u_dec (
    .idx_i      (idx_i),
    .vol_sel_o  (vol_sel),
    .id_sel_o   (id_sel),
    .cfg_sel_o  (cfg_sel),
    .misc_sel_o (misc_sel)
  );

  assign soft_rst = we_i & id_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 split_q <= 1'b0;
    else if (soft_rst)           split_q <= 1'b0;
    else if (we_i && misc_sel)   split_q <= wdata_i[SPLIT_BIT];
  end

  // survives the index-00h soft reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cfg_q <= '0;
    else if (we_i && cfg_sel)    cfg_q <= wdata_i[CFG_W-1:0];
  end

  for (genvar k = 0; k < NUM_VOL; k++) begin : g_vol
    codec_vol_reg #(.STEREO(VOL_STEREO[k])) u_vol (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .soft_rst_i (soft_rst),
      .wr_i       (we_i & vol_sel[k]),
      .wdata_i    (wdata_i),
      .split_i    (split_q),
      .rd_o       (vol_rd[k]),
      .att_l_o    (atten_o[(2*k)*ATT_W +: ATT_W]),
      .att_r_o    (atten_o[(2*k+1)*ATT_W +: ATT_W]),
      .mute_l_o   (mute_o[2*k]),
      .mute_r_o   (mute_o[2*k+1])
    );
  end

  always_comb begin
    rd_next = '0;
    if (id_sel)   rd_next = {{(DW-10){1'b0}}, ID_CODE};
    if (cfg_sel)  rd_next[CFG_W-1:0] = cfg_q;
    if (misc_sel) rd_next[SPLIT_BIT] = split_q;
    for (int k = 0; k < NUM_VOL; k++)
      if (vol_sel[k]) rd_next = vol_rd[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_next;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/codec_ctrl_regs_chk.sv
module codec_ctrl_regs_chk
  import codec_regs_pkg::*;
#(
  parameter logic [9:0] ID_CODE = 10'h190
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [IW-1:0]          idx_i,
  input logic [DW-1:0]          wdata_i,
  input logic                   we_i,
  input logic                   re_i,
  input logic [DW-1:0]          rdata_o,
  input logic [LANES*ATT_W-1:0] atten_o,
  input logic [LANES-1:0]       mute_o,
  input logic                   split_i
);
  logic unused_w;
  assign unused_w = ^{wdata_i[DW-1:ATT_W+1], wdata_i[ATT_W-1:0]};

  a_r2_soft_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && idx_i[IW-1:1] == IDX_ID[IW-1:1]) |=> (mute_o == '1 && atten_o == '0));

  a_r3_id_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && idx_i[IW-1:1] == IDX_ID[IW-1:1]) |=> (rdata_o == {6'b0, ID_CODE}));

  a_r5_right_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && idx_i[IW-1:1] == VOL_IDX[0][IW-1:1] && wdata_i[ATT_W])
    |=> (atten_o[ATT_W +: ATT_W] == '1));

  a_r8_unknown_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !idx_known(idx_i)) |=> (rdata_o == '0));

  a_r10_read_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));

  for (genvar k = 0; k < NUM_VOL; k++) begin : g_lane
    if (VOL_STEREO[k]) begin : g_st
      a_r7_right_follows_left: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !split_i |-> (mute_o[2*k+1] == mute_o[2*k]));
    end else begin : g_mo
      a_r6_mono_lanes_equal: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mute_o[2*k+1] == mute_o[2*k]) &&
        (atten_o[(2*k+1)*ATT_W +: ATT_W] == atten_o[(2*k)*ATT_W +: ATT_W]));
    end
  end
endmodule

bind codec_ctrl_regs codec_ctrl_regs_chk #(.ID_CODE(ID_CODE)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .idx_i   (idx_i),
  .wdata_i (wdata_i),
  .we_i    (we_i),
  .re_i    (re_i),
  .rdata_o (rdata_o),
  .atten_o (atten_o),
  .mute_o  (mute_o),
  .split_i (split_q)
);

// File: tb/codec_ctrl_regs_test.sv
module codec_ctrl_regs_test;
  localparam logic [6:0] TIDX [9] =
    '{7'h02, 7'h04, 7'h06, 7'h0C, 7'h0E, 7'h10, 7'h12, 7'h16, 7'h18};
  localparam logic [8:0]  TST    = 9'b1_1110_0011;
  localparam logic [15:0] ID_EXP = 16'h0190;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  idx_i = '0;
  logic [15:0] wdata_i = '0;
  logic        we_i = 1'b0, re_i = 1'b0;
  logic [15:0] rdata_o;
  logic [89:0] atten_o;
  logic [17:0] mute_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [15:0] mem [64];

  always #10ns clk = ~clk;

  codec_ctrl_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .idx_i(idx_i), .wdata_i(wdata_i),
    .we_i(we_i), .re_i(re_i), .rdata_o(rdata_o), .atten_o(atten_o), .mute_o(mute_o)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int vol_pos(input logic [6:0] idx);
    for (int k = 0; k < 9; k++) if (TIDX[k][6:1] == idx[6:1]) return k;
    return -1;
  endfunction

  function automatic logic [4:0] sat5(input logic [5:0] f);
    return f[5] ? 5'h1F : f[4:0];
  endfunction

  function automatic void model_defaults(input bit keep_cfg);
    logic [15:0] cfg;
    cfg = mem[7'h74 >> 1];
    for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
    for (int k = 0; k < 9; k++) mem[TIDX[k] >> 1] = 16'h8000;
    if (keep_cfg) mem[7'h74 >> 1] = cfg;
  endfunction

  function automatic void model_write(input logic [6:0] idx, input logic [15:0] d);
    int a, p;
    a = int'(idx >> 1);
    p = vol_pos(idx);
    if (a == 0) model_defaults(1'b1);
    else if (p >= 0) begin
      if (TST[p]) mem[a] = {d[15], 2'b00, sat5(d[13:8]), d[7], 2'b00, sat5(d[5:0])};
      else        mem[a] = {d[15], 10'b0, sat5(d[5:0])};
    end
    else if (a == (7'h74 >> 1)) mem[a] = d & 16'h00FF;
    else if (a == (7'h76 >> 1)) mem[a] = d & 16'h1000;
  endfunction

  function automatic logic [15:0] model_read(input logic [6:0] idx);
    if (idx[6:1] == 6'd0) return ID_EXP;
    return mem[idx >> 1];
  endfunction

  function automatic logic [89:0] exp_att();
    logic [89:0] a;
    logic [15:0] v;
    for (int k = 0; k < 9; k++) begin
      v = mem[TIDX[k] >> 1];
      a[10*k +: 5]     = TST[k] ? v[12:8] : v[4:0];
      a[10*k + 5 +: 5] = v[4:0];
    end
    return a;
  endfunction

  function automatic logic [17:0] exp_mute();
    logic [17:0] m;
    logic [15:0] v;
    logic split;
    split = mem[7'h76 >> 1][12];
    for (int k = 0; k < 9; k++) begin
      v = mem[TIDX[k] >> 1];
      m[2*k]   = v[15];
      m[2*k+1] = (TST[k] && split) ? v[7] : v[15];
    end
    return m;
  endfunction

  task automatic op(input bit w, input bit r, input logic [6:0] idx,
                    input logic [15:0] d, input string req);
    logic [15:0] exp_rd;
    logic [15:0] prev;
    exp_rd = model_read(idx);
    prev   = rdata_o;
    @(negedge clk);
    we_i = w; re_i = r; idx_i = idx; wdata_i = d;
    @(negedge clk);
    we_i = 1'b0; re_i = 1'b0;
    if (w) model_write(idx, d);
    if (r) check({req, " R10 read data"}, 128'(rdata_o), 128'(exp_rd));
    else   check("R10 read data held", 128'(rdata_o), 128'(prev));
    check({req, " R4/R7 lane attenuation"}, 128'(atten_o), 128'(exp_att()));
    check({req, " R4/R7 lane mute"}, 128'(mute_o), 128'(exp_mute()));
  endtask

  task automatic rd_lit(input logic [6:0] idx, input logic [15:0] lit, input string req);
    @(negedge clk);
    re_i = 1'b1; idx_i = idx;
    @(negedge clk);
    re_i = 1'b0;
    check(req, 128'(rdata_o), 128'(lit));
  endtask

  initial begin
    #(20ns * 100000);
    $display("FAIL watchdog: actual timeout expected completion");
    n_chk++; n_fail++;
    if (!done) begin
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    model_defaults(1'b0);
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 reset mute", 128'(mute_o), 128'(18'h3FFFF));
    check("R9 reset attenuation", 128'(atten_o), 128'(0));
    rd_lit(7'h02, 16'h8000, "R9 master default");
    rd_lit(7'h74, 16'h0000, "R9 config default");
    rd_lit(7'h76, 16'h0000, "R9 control default");
    // R3 / R1 identity
    rd_lit(7'h00, ID_EXP, "R3 identity read");
    rd_lit(7'h01, ID_EXP, "R1 odd identity alias");
    op(1'b1, 1'b0, 7'h00, 16'h7C00, "R3 write to id");
    rd_lit(7'h00, ID_EXP, "R3 identity unchanged");
    // R5 saturation
    op(1'b1, 1'b0, 7'h02, 16'h2525, "R5 sat write");
    rd_lit(7'h02, 16'h1F1F, "R5 saturated readback");
    // R1 odd write
    op(1'b1, 1'b0, 7'h03, 16'h0C07, "R1 odd write");
    rd_lit(7'h02, 16'h0C07, "R1 odd alias readback");
    // R6 mono
    op(1'b1, 1'b0, 7'h06, 16'h003F, "R6 mono sat");
    rd_lit(7'h06, 16'h001F, "R6 mono readback");
    op(1'b1, 1'b0, 7'h0F, 16'h8011, "R6 mic via odd");
    rd_lit(7'h0E, 16'h8011, "R6 mic readback");
    // R8 reserved / unknown
    op(1'b1, 1'b0, 7'h10, 16'hFFFF, "R8 reserved bits");
    rd_lit(7'h10, 16'h9F9F, "R8 reserved read zero");
    op(1'b1, 1'b0, 7'h20, 16'hFFFF, "R8 unknown write");
    rd_lit(7'h20, 16'h0000, "R8 unknown read");
    op(1'b1, 1'b0, 7'h7E, 16'hFFFF, "R8 unknown write hi");
    // R7 mute split
    op(1'b1, 1'b0, 7'h76, 16'hFFFF, "R7 split on");
    rd_lit(7'h76, 16'h1000, "R7 control readback");
    op(1'b1, 1'b0, 7'h02, 16'h8000, "R7 left only mute");
    check("R7 split right unmuted", 128'(mute_o[1:0]), 128'(2'b01));
    op(1'b1, 1'b0, 7'h76, 16'h0000, "R7 split off");
    check("R7 common mute", 128'(mute_o[1:0]), 128'(2'b11));
    op(1'b1, 1'b0, 7'h02, 16'h0080, "R7 bit7 ignored");
    check("R7 bit7 ignored lanes", 128'(mute_o[1:0]), 128'(2'b00));
    // R11 / R2 soft reset keeps config
    op(1'b1, 1'b0, 7'h74, 16'hA55A, "R11 config write");
    rd_lit(7'h74, 16'h005A, "R11 config readback");
    op(1'b1, 1'b0, 7'h76, 16'h1000, "R2 split on before reset");
    op(1'b1, 1'b0, 7'h01, 16'h1234, "R2 soft reset");
    rd_lit(7'h74, 16'h005A, "R2 config retained");
    rd_lit(7'h10, 16'h8000, "R2 line default");
    rd_lit(7'h76, 16'h0000, "R2 control default");
    check("R2 all muted", 128'(mute_o), 128'(18'h3FFFF));
    // R10 read during write returns old value
    op(1'b1, 1'b1, 7'h04, 16'h0303, "R10 read with write");
    rd_lit(7'h04, 16'h0303, "R10 later read");
    op(1'b0, 1'b0, 7'h04, 16'h0000, "R10 idle hold");
    // random phase
    for (int i = 0; i < 800; i++) begin
      logic [6:0] idx;
      int sel;
      bit w, r;
      sel = int'($urandom_range(0, 99));
      if (sel < 2)        idx = 7'h00;
      else if (sel < 75)  idx = TIDX[$urandom_range(0, 8)];
      else if (sel < 82)  idx = 7'h74;
      else if (sel < 92)  idx = 7'h76;
      else                idx = 7'($urandom);
      idx[0] = 1'($urandom);
      w = 1'($urandom);
      r = 1'($urandom);
      if (idx[6:1] == 6'd0 && $urandom_range(0, 3) != 0) w = 1'b0;
      op(w, r, idx, 16'($urandom), "R1/R4/R5/R6/R8 random");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule